// File: doc/BRIEF.md
# Cascadable Backplane Phase Sequencer

This block steps a multiplexed LCD through its backplane phases. A single-cycle frame tick advances the phase. One backplane output per phase goes low while that phase is active. The multiplex setting selects 1, 2, 3 or 4 active phases. Several identical chips can share one display. Each chip carries this sequencer, and all of them sit on one shared, open-drain synchronisation line.

A chip pulls the line low for the whole of its last active phase. In every other phase it only listens. A chip that is not driving and sees the line low has fallen out of step. It jumps to its own last phase at once, so the next frame tick moves it to phase 0 together with the chip that pulled the line. The line is modelled as a drive-low enable output plus an already synchronised level input. After reset every chip starts from the same state, so chips reset together are in step without any line activity.

Top module: `lcd_bp_sequencer`

## Requirements
- R1: While reset is asserted, `bp_n` is 4'b1110 (phase 0) and `sync_drive` is 0, whatever the multiplex setting.
- R2: Exactly one bit of `bp_n` is low at any time: bit i is low when phase i is active. Bits at or above the active phase count stay high.
- R3: `mux_mode` value m selects m+1 active phases (0 static, 1 two-way, 2 three-way, 3 four-way). On a frame tick the phase advances by one and wraps to 0 after phase m.
- R4: `sync_drive` is high exactly while the last active phase (phase m) is shown, and changes in the same cycle as `bp_n`.
- R5: In any cycle where `sync_drive` is low and `sync_in` is low, the next cycle shows the last active phase, with or without a tick. The following tick then moves to phase 0.
- R6: While `sync_drive` is high, `sync_in` is ignored: a tick from the last phase moves to phase 0 even with `sync_in` low.
- R7: With no tick and `sync_in` high, the phase and `sync_drive` hold.
- R8: When `mux_mode` differs from the setting in use, the next cycle shows phase 0 under the new setting, whatever the tick and `sync_in` are doing.
- R9: Two instances with one shared tick, one setting and a wired-AND line (`sync_in` = NOR of both drives) stay in step from reset. After they are put out of step, they are back in step within one frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_tick | input | 1 | Single-cycle phase advance strobe |
| mux_mode | input | 2 | Active phase count minus one |
| sync_in | input | 1 | Synchronised level of the shared line (low = asserted) |
| sync_drive | output | 1 | Pull the shared line low when high |
| bp_n | output | 4 | Active-low backplane phase outputs |

## Verification
The properties treat `sync_in` and `frame_tick` as clean, synchronised levels that may take any value in any cycle. The bench does the same: it toggles both at random at negative clock edges, with no protocol relation to the phase. The properties compare `mux_mode` with the setting in use, so they put no restriction on when the setting changes. The bench changes the setting at random as well, and changes it back directly for short disturbances. In the cascade section the line is driven only by the two instances' own drive outputs, which matches the wired-AND behaviour the properties describe.

// File: rtl/lcd_bp_pkg.sv
package lcd_bp_pkg;

    // What the phase counter does in the next cycle
    typedef enum logic [1:0] {
        ADV_HOLD      = 2'd0,
        ADV_NEXT      = 2'd1,
        ADV_LOAD_LAST = 2'd2,
        ADV_RESTART   = 2'd3
    } adv_e;

endpackage

// File: rtl/lcd_bp_phase_step.sv
module lcd_bp_phase_step
    import lcd_bp_pkg::*;
#(
    parameter int PH_W = 2
) (
    input  logic [PH_W-1:0] phase_q,
    input  logic [PH_W-1:0] last_phase,
    input  adv_e            action,
    output logic [PH_W-1:0] phase_d
);

    always_comb begin
        unique case (action)
            ADV_HOLD:      phase_d = phase_q;
            ADV_NEXT:      phase_d = (phase_q == last_phase) ? '0 : PH_W'(phase_q + 1'b1);
            ADV_LOAD_LAST: phase_d = last_phase;
            ADV_RESTART:   phase_d = '0;
            default:       phase_d = '0;
        endcase
    end

endmodule

// File: rtl/lcd_bp_decode.sv
module lcd_bp_decode #(
    parameter int NUM_BP = 4,
    parameter int PH_W   = 2
) (
    input  logic [PH_W-1:0]   phase,
    output logic [NUM_BP-1:0] bp_n
);

    for (genvar i = 0; i < NUM_BP; i++) begin : g_bp
        assign bp_n[i] = (phase != PH_W'(i));
    end

endmodule

// File: rtl/lcd_bp_sequencer.sv
module lcd_bp_sequencer
    import lcd_bp_pkg::*;
#(
    parameter int  NUM_BP = 4,
    localparam int PH_W   = (NUM_BP > 1) ? $clog2(NUM_BP) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_tick,
    input  logic [PH_W-1:0]   mux_mode,
    input  logic              sync_in,
    output logic              sync_drive,
    output logic [NUM_BP-1:0] bp_n
);

    localparam logic [PH_W-1:0] LAST_MAX = PH_W'(NUM_BP - 1);

    typedef struct packed {
        logic [PH_W-1:0]   phase;
        logic [PH_W-1:0]   mode;
        logic              drive;
        logic [NUM_BP-1:0] bp_n;
    } seq_state_t;

    seq_state_t state_d, state_q;

    logic [PH_W-1:0]   mode_used;
    logic [PH_W-1:0]   mode_req;
    logic [PH_W-1:0]   phase_nx;
    logic [NUM_BP-1:0] bp_nx;
    logic              mode_change;
    adv_e              action;

    assign mode_used = state_q.mode;
    assign mode_req  = (mux_mode > LAST_MAX) ? LAST_MAX : mux_mode;

    // Restart wins, then realignment from the shared line, then the tick
    always_comb begin
        mode_change = (mode_req != mode_used);
        if (mode_change)
            action = ADV_RESTART;
        else if (!state_q.drive && !sync_in)
            action = ADV_LOAD_LAST;
        else if (frame_tick)
            action = ADV_NEXT;
        else
            action = ADV_HOLD;
    end

    lcd_bp_phase_step #(
        .PH_W(PH_W)
    ) u_step (
        .phase_q    (state_q.phase),
        .last_phase (mode_used),
        .action     (action),
        .phase_d    (phase_nx)
    );

    lcd_bp_decode #(
        .NUM_BP(NUM_BP),
        .PH_W  (PH_W)
    ) u_decode (
        .phase (phase_nx),
        .bp_n  (bp_nx)
    );

    always_comb begin
        state_d       = state_q;
        state_d.mode  = mode_req;
        state_d.phase = phase_nx;
        state_d.drive = (phase_nx == mode_req);
        state_d.bp_n  = bp_nx;
    end

    // Reset state: phase 0 of the widest setting, line released
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q.phase <= '0;
            state_q.mode  <= LAST_MAX;
            state_q.drive <= 1'b0;
            state_q.bp_n  <= ~NUM_BP'(1);
        end else begin
            state_q <= state_d;
        end
    end

    assign sync_drive = state_q.drive;
    assign bp_n       = state_q.bp_n;

endmodule

// File: rtl/lcd_bp_sequencer_chk.sv
module lcd_bp_sequencer_chk #(
    parameter int NUM_BP = 4,
    parameter int PH_W   = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              frame_tick,
    input logic [PH_W-1:0]   mux_mode,
    input logic [PH_W-1:0]   mode_used,
    input logic              sync_in,
    input logic              sync_drive,
    input logic [NUM_BP-1:0] bp_n
);

    localparam logic [NUM_BP-1:0] BP_PH0 = ~NUM_BP'(1);

    AST_ONE_BP_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(~bp_n) == 1); // R2

    AST_DRIVE_ON_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        sync_drive == !bp_n[mode_used]); // R4

    AST_MODE_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        (mux_mode != mode_used) |=> (bp_n == BP_PH0) && (mode_used == $past(mux_mode))); // R8

    AST_REALIGN: assert property (@(posedge clk) disable iff (!rst_n)
        (mux_mode == mode_used) && !sync_drive && !sync_in |=> sync_drive); // R5

    AST_WRAP_WHILE_DRIVING: assert property (@(posedge clk) disable iff (!rst_n)
        (mux_mode == mode_used) && sync_drive && frame_tick |=> (bp_n == BP_PH0)); // R6

    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (mux_mode == mode_used) && !frame_tick && sync_in |=> $stable(bp_n) && $stable(sync_drive)); // R7

endmodule

bind lcd_bp_sequencer lcd_bp_sequencer_chk #(
    .NUM_BP(NUM_BP),
    .PH_W  (PH_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .frame_tick (frame_tick),
    .mux_mode   (mux_mode),
    .mode_used  (mode_used),
    .sync_in    (sync_in),
    .sync_drive (sync_drive),
    .bp_n       (bp_n)
);

// File: tb/test_lcd_bp_sequencer.sv
`timescale 1ns/1ps
module test_lcd_bp_sequencer;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       frame_tick = 1'b0;
    logic [1:0] mux_mode = 2'd0;
    logic [1:0] peer_mode = 2'd0;
    logic       peer_alt = 1'b0;
    logic       tb_sync_n = 1'b1;
    logic       cascade_en = 1'b0;
    logic       dut_drive, peer_drive;
    logic [3:0] dut_bp_n, peer_bp_n;
    logic       sync_line, dut_sync_in;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    // model state
    logic [1:0] m_phase;
    logic [1:0] m_mode;
    logic       m_drive;

    always #2.5 clk = ~clk;

    assign sync_line   = ~(dut_drive | peer_drive);
    assign dut_sync_in = cascade_en ? sync_line : tb_sync_n;

    lcd_bp_sequencer i_lcd_bp_sequencer (
        .clk(clk), .rst_n(rst_n), .frame_tick(frame_tick), .mux_mode(mux_mode),
        .sync_in(dut_sync_in), .sync_drive(dut_drive), .bp_n(dut_bp_n)
    );

    lcd_bp_sequencer i_peer (
        .clk(clk), .rst_n(rst_n), .frame_tick(frame_tick), .mux_mode(peer_mode),
        .sync_in(sync_line), .sync_drive(peer_drive), .bp_n(peer_bp_n)
    );

    function automatic logic [1:0] next_phase(input logic [1:0] ph, input logic [1:0] md,
                                              input logic drv, input logic [1:0] req,
                                              input logic tick, input logic snc);
        if (req != md)       return 2'd0;
        if (!drv && !snc)    return md;
        if (tick)            return (ph == md) ? 2'd0 : ph + 2'd1;
        return ph;
    endfunction

    function automatic logic [3:0] bp_of(input logic [1:0] ph);
        return ~(4'b0001 << ph);
    endfunction

    task automatic check(input string tag, input logic [3:0] act, input logic [3:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%b expected=%b", tag, act, exp);
        end
    endtask

    task automatic model_reset();
        m_phase = 2'd0; m_mode = 2'd3; m_drive = 1'b0;
    endtask

    // Call at a negative edge; returns at the next negative edge after checking
    task automatic step(input logic tick, input logic [1:0] md, input logic snc);
        string tag;
        logic [1:0] np;
        frame_tick = tick;
        mux_mode   = md;
        peer_mode  = peer_alt ? ~md : md;
        tb_sync_n  = snc;
        #1;
        if (md != m_mode)                         tag = "R8";
        else if (!m_drive && !dut_sync_in)        tag = "R5";
        else if (m_drive && !dut_sync_in && tick) tag = "R6";
        else if (tick)                            tag = "R3";
        else                                      tag = "R7";
        np = next_phase(m_phase, m_mode, m_drive, md, tick, dut_sync_in);
        m_phase = np; m_mode = md; m_drive = (np == md);
        @(negedge clk);
        check(tag, dut_bp_n, bp_of(m_phase));
        check("R4", {3'b0, dut_drive}, {3'b0, m_drive});
        check("R2", {3'b0, ($countones(~dut_bp_n) == 1)}, 4'd1);
    endtask

    initial begin
        process::self().srandom(32'd20240611);
        model_reset();
        // R1: reset state with static setting (phase 0 is also the last phase)
        mux_mode = 2'd0;
        repeat (3) @(negedge clk);
        check("R1", dut_bp_n, 4'b1110);
        check("R1", {3'b0, dut_drive}, 4'd0);
        rst_n = 1'b1;
        step(1'b0, 2'd3, 1'b1);

        // R3 four-way cycle
        for (int i = 0; i < 6; i++) step(1'b1, 2'd3, 1'b1);
        // R8 then R3 three-way: 0,1,2,0
        step(1'b0, 2'd2, 1'b1);
        check("R8", dut_bp_n, 4'b1110);
        for (int i = 0; i < 3; i++) step(1'b1, 2'd2, 1'b1);
        check("R3", dut_bp_n, 4'b1110);
        // R3/R4 static: always phase 0, drive high
        step(1'b0, 2'd0, 1'b1);
        for (int i = 0; i < 3; i++) step(1'b1, 2'd0, 1'b1);
        check("R4", {3'b0, dut_drive}, 4'd1);
        // R5 realign without a tick
        step(1'b0, 2'd3, 1'b1);
        step(1'b1, 2'd3, 1'b1);
        step(1'b0, 2'd3, 1'b0);
        check("R5", dut_bp_n, 4'b0111);
        step(1'b1, 2'd3, 1'b1);
        check("R5", dut_bp_n, 4'b1110);
        // R6 line ignored while driving
        for (int i = 0; i < 3; i++) step(1'b1, 2'd3, 1'b1);
        step(1'b1, 2'd3, 1'b0);
        check("R6", dut_bp_n, 4'b1110);
        // R7 hold
        step(1'b1, 2'd3, 1'b1);
        for (int i = 0; i < 4; i++) step(1'b0, 2'd3, 1'b1);
        check("R7", dut_bp_n, 4'b1101);
        // R8 restart with tick and line low at once
        step(1'b1, 2'd1, 1'b0);
        check("R8", dut_bp_n, 4'b1110);

        // random section
        for (int i = 0; i < 3000; i++) begin
            logic [1:0] md;
            md = ($urandom_range(0, 19) == 0) ? 2'($urandom_range(0, 3)) : m_mode;
            step($urandom_range(0, 2) == 0, md, $urandom_range(0, 7) != 0);
        end

        // R9 cascade: fresh reset, both in step with no line event
        @(negedge clk);
        rst_n = 1'b0; cascade_en = 1'b1; mux_mode = 2'd3; peer_mode = 2'd3;
        model_reset();
        @(negedge clk);
        rst_n = 1'b1;
        for (int i = 0; i < 10; i++) begin
            step(1'b1, 2'd3, 1'b1);
            check("R9", peer_bp_n, dut_bp_n);
        end
        // disturb the peer for one cycle, then let the line pull it back
        step(1'b1, 2'd3, 1'b1);
        step(1'b1, 2'd3, 1'b1);
        peer_alt = 1'b1;
        step(1'b0, 2'd3, 1'b1);
        peer_alt = 1'b0;
        step(1'b0, 2'd3, 1'b1);
        check("R9", {3'b0, (peer_bp_n != dut_bp_n)}, 4'd1);
        for (int i = 0; i < 8; i++) begin
            step(1'b1, 2'd3, 1'b1);
            step(1'b0, 2'd3, 1'b1);
        end
        for (int i = 0; i < 6; i++) begin
            step(1'b1, 2'd3, 1'b1);
            check("R9", peer_bp_n, dut_bp_n);
        end

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(5ns * 100000);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule